// File: doc/BRIEF.md
# Pipelined Immediate-Extension Combiner

This block forms the register boundary between two neighbouring stages of an in-order instruction pipeline, ahead of the execute stage. An instruction can carry only a 9-bit immediate in its S or D operand field. To reach a full 32-bit constant, the compiler places a trailing "augment" word directly after the instruction. That word is a no-op, and its low 23 bits are free payload. Each time the pipeline advances, the block looks at the instruction in the current stage and at the word one slot behind it. It then latches the widened operands into the next stage.

Because the extension word follows the instruction it extends, the pairing is resolved entirely from registers already in the pipeline, and no prefix state bit is held. When the augment word later reaches the current stage itself, the block strips its register and flag write enables, so that it retires as a one-cycle no-op. Only one execution thread is supported, so no per-thread payload storage exists.

Top module: `immext_top`

## Requirements
- R1: While reset (`rstN` low) is active, and after it until the first advance, `exValid`, `exRegWr`, `exFlagWr`, `exExtS` and `exExtD` are 0 and both operand outputs are 0.
- R2: When `advance` is 1, the current word is a valid non-augment with `curImmS`=1, and the word behind is a valid, uncancelled augment: one clock later `exSOperand` = {nxtPayload[22:0], curSField[8:0]} and `exExtS`=1.
- R3: As R2, but with `curImmS`=0 and `curImmD`=1: the D operand is extended as {nxtPayload, curDField}, `exExtD`=1, and the S operand is zero-extended.
- R4: When both `curImmS` and `curImmD` are 1, only S is extended. D is zero-extended, and `exExtS` and `exExtD` are never both 1.
- R5: An augment word marked cancelled (`nxtCancel`=1) extends nothing. Both operands are zero-extended and both extension flags are 0.
- R6: An instruction with neither immediate flag passes both 9-bit fields through zero-extended, with extension flags 0, even when a valid augment word sits behind it.
- R7: A current word that is itself an augment (`curIsAug`=1) is latched with `exValid`=1, `exRegWr`=0, `exFlagWr`=0 and no extension. Back-to-back augment words each give one such no-op cycle.
- R8: While `advance` is 0, every output holds its value. The instruction and the word behind it are paired only on the cycle the pipeline advances.
- R9: When the word behind is invalid, or is valid but not an augment, no extension takes place.
- R10: For a valid non-augment current word, `exRegWr` and `exFlagWr` follow `curRegWr` and `curFlagWr`. For an invalid current word, `exValid`, `exRegWr` and `exFlagWr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Pipeline advance; 0 holds the stage |
| curValid | input | 1 | Current-stage word is valid |
| curIsAug | input | 1 | Current-stage word is an augment no-op |
| curImmS | input | 1 | Current S operand is immediate |
| curImmD | input | 1 | Current D operand is immediate |
| curRegWr | input | 1 | Current word writes a register |
| curFlagWr | input | 1 | Current word writes flags |
| curSField | input | 9 | Current S field |
| curDField | input | 9 | Current D field |
| nxtValid | input | 1 | Word one slot behind is valid |
| nxtIsAug | input | 1 | Word behind is an augment |
| nxtCancel | input | 1 | Word behind is cancelled trailing code |
| nxtPayload | input | 23 | Payload of the word behind |
| exValid | output | 1 | Latched word is valid |
| exRegWr | output | 1 | Latched register write enable |
| exFlagWr | output | 1 | Latched flag write enable |
| exExtS | output | 1 | S operand was extended |
| exExtD | output | 1 | D operand was extended |
| exSOperand | output | 32 | Latched S operand |
| exDOperand | output | 32 | Latched D operand |

## Verification
Every result is registered once, so each output is due on the first rising edge after the advance cycle on which its stimulus was presented. The bench drives inputs on the falling edge and samples on the following falling edge, which lies exactly one register stage later. The hold checks keep `advance` low across several edges with altered inputs and confirm that nothing moves. They then release `advance` and confirm that the pair present on the releasing cycle is the one latched.

// File: rtl/immext_pkg.sv
package immext_pkg;
  localparam int IMM_W     = 9;
  localparam int PAY_W     = 23;
  localparam int OP_W      = IMM_W + PAY_W;
  localparam int NUM_LANES = 2;
  localparam int LANE_S    = 0;
  localparam int LANE_D    = 1;

  typedef struct packed {
    logic                 load;
    logic                 valid;
    logic [NUM_LANES-1:0] ext;
    logic                 wrReg;
    logic                 wrFlag;
  } ctrlStrobes_t;
endpackage

// File: rtl/immext_ctrl.sv
module immext_ctrl
  import immext_pkg::*;
(
  input  logic         advance,
  input  logic         curValid,
  input  logic         curIsAug,
  input  logic         curImmS,
  input  logic         curImmD,
  input  logic         curRegWr,
  input  logic         curFlagWr,
  input  logic         nxtValid,
  input  logic         nxtIsAug,
  input  logic         nxtCancel,
  output ctrlStrobes_t strobes
);
  logic realInstr;
  logic augUsable;

  // only a live, real instruction may consume a live, uncancelled trailer
  assign realInstr = curValid & ~curIsAug;
  assign augUsable = realInstr & nxtValid & nxtIsAug & ~nxtCancel;

  always_comb begin
    strobes             = '0;
    strobes.load        = advance;
    strobes.valid       = curValid;
    strobes.ext[LANE_S] = augUsable & curImmS;
    strobes.ext[LANE_D] = augUsable & curImmD & ~curImmS;  // S wins
    strobes.wrReg       = realInstr & curRegWr;
    strobes.wrFlag      = realInstr & curFlagWr;
  end
endmodule

// File: rtl/immext_lane.sv
module immext_lane #(
  parameter int IMM_W = 9,
  parameter int PAY_W = 23,
  localparam int OP_W = IMM_W + PAY_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             ext,
  input  logic [IMM_W-1:0] immIn,
  input  logic [PAY_W-1:0] payloadIn,
  output logic [OP_W-1:0]  operand,
  output logic             extFlag
);
  logic [PAY_W-1:0] highPart;

  assign highPart = ext ? payloadIn : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      operand <= '0;
      extFlag <= 1'b0;
    end else if (load) begin
      operand <= {highPart, immIn};
      extFlag <= ext;
    end
  end

  assert_zero_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    !extFlag |-> (operand[OP_W-1:IMM_W] == '0));
endmodule

// File: rtl/immext_datapath.sv
module immext_datapath
  import immext_pkg::*;
#(
  parameter int PIMM_W = IMM_W,
  parameter int PPAY_W = PAY_W,
  localparam int POP_W = PIMM_W + PPAY_W
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ctrlStrobes_t                     strobes,
  input  logic [NUM_LANES-1:0][PIMM_W-1:0] immFields,
  input  logic [PPAY_W-1:0]                payload,
  output logic [NUM_LANES-1:0][POP_W-1:0]  operands,
  output logic [NUM_LANES-1:0]             extFlags,
  output logic                             exValid,
  output logic                             exRegWr,
  output logic                             exFlagWr
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    immext_lane #(.IMM_W(PIMM_W), .PAY_W(PPAY_W)) uLane (
      .clk      (clk),
      .rstN     (rstN),
      .load     (strobes.load),
      .ext      (strobes.ext[g]),
      .immIn    (immFields[g]),
      .payloadIn(payload),
      .operand  (operands[g]),
      .extFlag  (extFlags[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      exValid  <= 1'b0;
      exRegWr  <= 1'b0;
      exFlagWr <= 1'b0;
    end else if (strobes.load) begin
      exValid  <= strobes.valid;
      exRegWr  <= strobes.wrReg;
      exFlagWr <= strobes.wrFlag;
    end
  end

  assert_single_ext_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(extFlags));
  assert_write_needs_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    (exRegWr || exFlagWr) |-> exValid);
endmodule

// File: rtl/immext_top.sv
module immext_top
  import immext_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  input  logic              curValid,
  input  logic              curIsAug,
  input  logic              curImmS,
  input  logic              curImmD,
  input  logic              curRegWr,
  input  logic              curFlagWr,
  input  logic [IMM_W-1:0]  curSField,
  input  logic [IMM_W-1:0]  curDField,
  input  logic              nxtValid,
  input  logic              nxtIsAug,
  input  logic              nxtCancel,
  input  logic [PAY_W-1:0]  nxtPayload,
  output logic              exValid,
  output logic              exRegWr,
  output logic              exFlagWr,
  output logic              exExtS,
  output logic              exExtD,
  output logic [OP_W-1:0]   exSOperand,
  output logic [OP_W-1:0]   exDOperand
);
  ctrlStrobes_t                    strobes;
  logic [NUM_LANES-1:0][IMM_W-1:0] immFields;
  logic [NUM_LANES-1:0][OP_W-1:0]  operands;
  logic [NUM_LANES-1:0]            extFlags;

  assign immFields[LANE_S] = curSField;
  assign immFields[LANE_D] = curDField;

  immext_ctrl uCtrl (
    .advance  (advance),
    .curValid (curValid),
    .curIsAug (curIsAug),
    .curImmS  (curImmS),
    .curImmD  (curImmD),
    .curRegWr (curRegWr),
    .curFlagWr(curFlagWr),
    .nxtValid (nxtValid),
    .nxtIsAug (nxtIsAug),
    .nxtCancel(nxtCancel),
    .strobes  (strobes)
  );

  immext_datapath #(.PIMM_W(IMM_W), .PPAY_W(PAY_W)) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .immFields(immFields),
    .payload  (nxtPayload),
    .operands (operands),
    .extFlags (extFlags),
    .exValid  (exValid),
    .exRegWr  (exRegWr),
    .exFlagWr (exFlagWr)
  );

  assign exSOperand = operands[LANE_S];
  assign exDOperand = operands[LANE_D];
  assign exExtS     = extFlags[LANE_S];
  assign exExtD     = extFlags[LANE_D];

  assert_aug_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    (advance && curIsAug) |=> (!exRegWr && !exFlagWr && !exExtS && !exExtD));
  assert_cancel_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (advance && nxtCancel) |=> (!exExtS && !exExtD));
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> ($stable(exSOperand) && $stable(exDOperand) && $stable(exValid)
                  && $stable(exRegWr) && $stable(exFlagWr)));
  assert_no_imm_plain_R6: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !curImmS && !curImmD) |=> (!exExtS && !exExtD));
endmodule

// File: tb/test_immext_top.sv
`timescale 1ns/1ps
module test_immext_top;
  logic clk = 1'b0;
  logic rstN;
  logic advance, curValid, curIsAug, curImmS, curImmD, curRegWr, curFlagWr;
  logic [8:0] curSField, curDField;
  logic nxtValid, nxtIsAug, nxtCancel;
  logic [22:0] nxtPayload;
  logic exValid, exRegWr, exFlagWr, exExtS, exExtD;
  logic [31:0] exSOperand, exDOperand;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  immext_top i_immext_top (.*);

  typedef struct packed {
    logic cv; logic ca; logic is; logic id; logic rw; logic fw;
    logic [8:0] s; logic [8:0] d;
    logic nv; logic na; logic nc; logic [22:0] pay;
    logic [31:0] eS; logic [31:0] eD;
    logic xS; logic xD; logic eRw; logic eFw;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    // R2: S extended
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 9'h0AB,9'h005, 1'b1,1'b1,1'b0,23'h000001,
      32'h0000_02AB,32'h0000_0005, 1'b1,1'b0,1'b1,1'b0, 4'd2},
    // R3: D extended
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 9'h010,9'h001, 1'b1,1'b1,1'b0,23'h400000,
      32'h0000_0010,32'h8000_0001, 1'b0,1'b1,1'b1,1'b1, 4'd3},
    // R4: both immediate, S wins
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b1, 9'h1FF,9'h0C3, 1'b1,1'b1,1'b0,23'h7FFFFF,
      32'hFFFF_FFFF,32'h0000_00C3, 1'b1,1'b0,1'b0,1'b1, 4'd4},
    // R5: cancelled augment
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 9'h123,9'h000, 1'b1,1'b1,1'b1,23'h0ABCDE,
      32'h0000_0123,32'h0, 1'b0,1'b0,1'b1,1'b0, 4'd5},
    // R6: no immediate
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 9'h123,9'h044, 1'b1,1'b1,1'b0,23'h0ABCDE,
      32'h0000_0123,32'h0000_0044, 1'b0,1'b0,1'b1,1'b1, 4'd6},
    // R9: trailer not an augment
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 9'h123,9'h000, 1'b1,1'b0,1'b0,23'h0ABCDE,
      32'h0000_0123,32'h0, 1'b0,1'b0,1'b1,1'b0, 4'd9},
    // R9: trailer invalid
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 9'h123,9'h000, 1'b0,1'b1,1'b0,23'h0ABCDE,
      32'h0000_0123,32'h0, 1'b0,1'b0,1'b1,1'b0, 4'd9},
    // R10 with R2: write enables follow, large payload
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1, 9'h123,9'h0FF, 1'b1,1'b1,1'b0,23'h0ABCDE,
      32'h1579_BD23,32'h0000_00FF, 1'b1,1'b0,1'b1,1'b1, 4'd10},
    // R7: augment word in current slot is silent
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 9'h07F,9'h000, 1'b1,1'b1,1'b0,23'h000055,
      32'h0000_007F,32'h0, 1'b0,1'b0,1'b0,1'b0, 4'd7}
  };

  task automatic checkVal(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    curValid = v.cv; curIsAug = v.ca; curImmS = v.is; curImmD = v.id;
    curRegWr = v.rw; curFlagWr = v.fw; curSField = v.s; curDField = v.d;
    nxtValid = v.nv; nxtIsAug = v.na; nxtCancel = v.nc; nxtPayload = v.pay;
  endtask

  task automatic checkVec(input vec_t v);
    string r;
    r = $sformatf("R%0d", v.req);
    checkVal(r, "exValid", {31'b0, exValid}, 32'd1);
    checkVal(r, "exSOperand", exSOperand, v.eS);
    checkVal(r, "exDOperand", exDOperand, v.eD);
    checkVal(r, "ext{S,D}", {30'b0, exExtS, exExtD}, {30'b0, v.xS, v.xD});
    checkVal(r, "wr{Reg,Flag}", {30'b0, exRegWr, exFlagWr}, {30'b0, v.eRw, v.eFw});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; advance = 1'b0;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    // R1: reset state
    checkVal("R1", "flags", {27'b0, exValid, exRegWr, exFlagWr, exExtS, exExtD}, 32'd0);
    checkVal("R1", "exSOperand", exSOperand, 32'd0);
    checkVal("R1", "exDOperand", exDOperand, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1", "post-reset flags", {27'b0, exValid, exRegWr, exFlagWr, exExtS, exExtD}, 32'd0);

    // vector table
    advance = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      checkVec(VECS[i]);
    end

    // R8: hold keeps outputs while inputs change
    drive(VECS[7]);
    @(negedge clk);
    advance = 1'b0;
    drive(VECS[1]);
    repeat (3) @(negedge clk);
    checkVal("R8", "held exSOperand", exSOperand, 32'h1579_BD23);
    checkVal("R8", "held exDOperand", exDOperand, 32'h0000_00FF);
    checkVal("R8", "held exExtS", {31'b0, exExtS}, 32'd1);
    // release: the pair present on the advancing cycle is latched
    drive(VECS[2]);
    advance = 1'b1;
    @(negedge clk);
    checkVec(VECS[2]);

    // R7: back-to-back augment words, each a silent no-op
    drive(VECS[8]);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checkVal("R7", "b2b valid", {31'b0, exValid}, 32'd1);
      checkVal("R7", "b2b writes/ext", {28'b0, exRegWr, exFlagWr, exExtS, exExtD}, 32'd0);
    end

    // R10: invalid current word
    drive(VECS[7]);
    curValid = 1'b0;
    @(negedge clk);
    checkVal("R10", "invalid", {29'b0, exValid, exRegWr, exFlagWr}, 32'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule